// File: doc/BRIEF.md
# Checkpointed Register Rename Map

This block is the mapping table of a renaming processor core. It holds one entry per physical register, and each entry records which architectural register that physical register currently stands for, together with a valid bit. A rename stage writes a new pairing of architectural and physical register in the cycle it asserts its enable. Any older physical register that still claimed the same architectural name loses its claim in that same write, so each architectural name maps to at most one physical register.

Lookups are associative. An architectural number is compared against every valid entry at once, and the block returns the matching physical index and a hit flag in the same cycle. When a branch is renamed, the front end requests a checkpoint. The block copies the whole table into a free snapshot slot and returns a small tag for it. If the branch later turns out to be mispredicted, the core presents that tag. In one cycle the table reloads from the snapshot, and that slot and every slot taken after it are released.

Checkpoints are allocated in age order and are released only by a restore. When every slot is occupied, a further request is refused with a stall indication and nothing is saved.

Top module: `rmap_table`

## Requirements
- R1: After reset, physical entries 0 to 31 hold architectural numbers 0 to 31 (entry i holds i) and are valid. Entries 32 to 63 are invalid. A lookup of any architectural number from 32 to 63 therefore misses.
- R2: Lookup is combinational. If a valid entry holds `lk_arch`, then `lk_hit` is 1 and `lk_phys` is that entry's index. Otherwise `lk_hit` is 0 and `lk_phys` is 0.
- R3: When `ren_en` is 1 and no restore is active, the next clock edge makes entry `ren_phys` valid with architectural number `ren_arch`. The same edge invalidates every other entry that held `ren_arch`, so at most one valid entry matches any architectural number.
- R4: When `ckpt_req` is 1, no restore is active and fewer than 4 checkpoints are live, `ckpt_grant` is 1 in that cycle. `ckpt_tag` equals the number of live checkpoints, so tags are handed out 0, 1, 2, 3 in order. The snapshot holds the table as it stood at the start of that cycle and excludes any rename written at the same edge.
- R5: When `ckpt_req` is 1 while 4 checkpoints are live and no restore is active, `ckpt_stall` is 1 and `ckpt_grant` is 0. Nothing is saved and the live count is unchanged.
- R6: When `rst_en` is 1 and tag `rst_tag` is live, the next edge loads the whole table from that snapshot. The restored slot and all younger slots are released, so the next granted tag equals `rst_tag`.
- R7: A restore takes priority. A rename in the same cycle is dropped, and a checkpoint request in the same cycle is neither granted nor stalled.
- R8: A restore whose tag is not live is ignored. The table and the checkpoint count are unchanged, and a rename in the same cycle takes effect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_en | input | 1 | Write a new mapping this cycle |
| ren_arch | input | 6 | Architectural number being renamed |
| ren_phys | input | 6 | Physical entry that receives it |
| lk_arch | input | 6 | Architectural number to look up |
| lk_hit | output | 1 | A valid entry holds `lk_arch` |
| lk_phys | output | 6 | Index of the matching entry |
| ckpt_req | input | 1 | Save the table into a new snapshot |
| ckpt_grant | output | 1 | Snapshot accepted this cycle |
| ckpt_stall | output | 1 | Snapshot refused, all slots live |
| ckpt_tag | output | 2 | Tag of the snapshot being taken |
| rst_en | input | 1 | Restore the table from a snapshot |
| rst_tag | input | 2 | Snapshot to restore |

## Verification
A vector table first sweeps lookups over the reset mapping: low names that must hit their own index, and high names that must miss with a zero index. This separates the identity load from the invalid upper half. Renames that reuse one architectural name several times check that the older claim is cleared rather than left as a second match. A checkpoint is taken in the same cycle as a rename and later restored, which shows whether the snapshot is taken before or after that edge's write. The tests fill all four slots until the stall appears, restore a middle slot while a rename and a request are also pending, and then restore a tag that is no longer live. Together these separate correct slot release, correct priority and correct handling of a stale tag from mistakes that give similar-looking lookups.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  parameter int NUM_PHYS = 64;
  parameter int ARCH_W   = 6;
  parameter int NUM_CKPT = 4;
  parameter int NUM_BOOT = 32;

  localparam int PHYS_W = $clog2(NUM_PHYS);
  localparam int TAG_W  = $clog2(NUM_CKPT);
  localparam int CNT_W  = $clog2(NUM_CKPT + 1);

  typedef struct packed {
    logic              valid;
    logic [ARCH_W-1:0] arch;
  } map_entry_t;
endpackage

// File: rtl/rmap_cam.sv
module rmap_cam
  import rmap_pkg::*;
(
  input  map_entry_t        entries [NUM_PHYS],
  input  logic [ARCH_W-1:0] key,
  output logic [NUM_PHYS-1:0] match,
  output logic              hit,
  output logic [PHYS_W-1:0] idx
);
  genvar g;
  generate
    for (g = 0; g < NUM_PHYS; g++) begin : g_cmp
      assign match[g] = entries[g].valid && (entries[g].arch == key);
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    idx = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (match[i]) idx = PHYS_W'(i);
    end
  end
endmodule

// File: rtl/rmap_ckpt_ctrl.sv
module rmap_ckpt_ctrl
  import rmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             restore_en,
  input  logic [TAG_W-1:0] restore_tag,
  output logic             grant,
  output logic             stall,
  output logic [TAG_W-1:0] tag,
  output logic             restore_live,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  assign full         = (cnt_q == CNT_W'(NUM_CKPT));
  assign restore_live = restore_en && (CNT_W'(restore_tag) < cnt_q);
  assign grant        = req && !restore_en && !full;
  assign stall        = req && !restore_en && full;
  assign tag          = cnt_q[TAG_W-1:0];
  assign cnt          = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restore_live)  cnt_d = CNT_W'(restore_tag);
    else if (grant)    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rmap_table.sv
module rmap_table
  import rmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_en,
  input  logic [ARCH_W-1:0] ren_arch,
  input  logic [PHYS_W-1:0] ren_phys,
  input  logic [ARCH_W-1:0] lk_arch,
  output logic              lk_hit,
  output logic [PHYS_W-1:0] lk_phys,
  input  logic              ckpt_req,
  output logic              ckpt_grant,
  output logic              ckpt_stall,
  output logic [TAG_W-1:0]  ckpt_tag,
  input  logic              rst_en,
  input  logic [TAG_W-1:0]  rst_tag
);
  map_entry_t map_q [NUM_PHYS];
  map_entry_t map_d [NUM_PHYS];
  map_entry_t snap_q [NUM_CKPT][NUM_PHYS];

  logic [NUM_PHYS-1:0] lk_match;
  logic [NUM_PHYS-1:0] ren_match;
  logic                ren_hit_unused;
  logic [PHYS_W-1:0]   ren_idx_unused;
  logic                restore_live;
  logic [CNT_W-1:0]    ckpt_cnt;

  rmap_cam u_lk_cam (
    .entries(map_q), .key(lk_arch),
    .match(lk_match), .hit(lk_hit), .idx(lk_phys)
  );

  rmap_cam u_ren_cam (
    .entries(map_q), .key(ren_arch),
    .match(ren_match), .hit(ren_hit_unused), .idx(ren_idx_unused)
  );

  rmap_ckpt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(ckpt_req),
    .restore_en(rst_en), .restore_tag(rst_tag),
    .grant(ckpt_grant), .stall(ckpt_stall), .tag(ckpt_tag),
    .restore_live(restore_live), .cnt(ckpt_cnt)
  );

  genvar g, s;
  generate
    for (g = 0; g < NUM_PHYS; g++) begin : g_ent
      always_comb begin
        map_d[g] = map_q[g];
        if (restore_live) begin
          map_d[g] = snap_q[rst_tag][g];
        end else if (ren_en) begin
          if (ren_match[g]) map_d[g].valid = 1'b0;
          if (ren_phys == PHYS_W'(g)) begin
            map_d[g].valid = 1'b1;
            map_d[g].arch  = ren_arch;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          map_q[g].valid <= (g < NUM_BOOT);
          map_q[g].arch  <= ARCH_W'(g);
        end else begin
          map_q[g] <= map_d[g];
        end
      end
    end

    for (s = 0; s < NUM_CKPT; s++) begin : g_snap
      logic snap_we;
      assign snap_we = ckpt_grant && (ckpt_tag == TAG_W'(s));
      always_ff @(posedge clk) begin
        if (snap_we) snap_q[s] <= map_q;
      end
    end
  endgenerate
endmodule

// File: rtl/rmap_checker.sv
module rmap_checker
  import rmap_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                ckpt_grant,
  input logic                ckpt_stall,
  input logic                rst_en,
  input logic [TAG_W-1:0]    rst_tag,
  input logic [NUM_PHYS-1:0] lk_match,
  input logic [CNT_W-1:0]    cnt
);
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  p_grant_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_grant |=> cnt == $past(cnt) + CNT_W'(1));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_stall |=> cnt == $past(cnt));

  p_restore_trim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_en && (CNT_W'(rst_tag) < cnt)) |=> cnt == CNT_W'($past(rst_tag)));

  p_restore_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_en |-> (!ckpt_grant && !ckpt_stall));

  p_stale_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_en && (CNT_W'(rst_tag) >= cnt)) |=> cnt == $past(cnt));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(NUM_CKPT));
endmodule

bind rmap_table rmap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ckpt_grant(ckpt_grant), .ckpt_stall(ckpt_stall),
  .rst_en(rst_en), .rst_tag(rst_tag), .lk_match(lk_match), .cnt(ckpt_cnt)
);

// File: tb/tb_rmap_table.sv
module tb_rmap_table;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       ren_en;
  logic [5:0] ren_arch, ren_phys, lk_arch, lk_phys;
  logic       lk_hit, ckpt_req, ckpt_grant, ckpt_stall, rst_en;
  logic [1:0] ckpt_tag, rst_tag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  rmap_table dut (
    .clk(clk), .rst_n(rst_n), .ren_en(ren_en), .ren_arch(ren_arch),
    .ren_phys(ren_phys), .lk_arch(lk_arch), .lk_hit(lk_hit), .lk_phys(lk_phys),
    .ckpt_req(ckpt_req), .ckpt_grant(ckpt_grant), .ckpt_stall(ckpt_stall),
    .ckpt_tag(ckpt_tag), .rst_en(rst_en), .rst_tag(rst_tag)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {arch, hit, phys}
  localparam logic [12:0] LK_VEC [8] = '{
    {6'd0,  1'b1, 6'd0},  {6'd31, 1'b1, 6'd31},
    {6'd17, 1'b1, 6'd17}, {6'd32, 1'b0, 6'd0},
    {6'd63, 1'b0, 6'd0},  {6'd1,  1'b1, 6'd1},
    {6'd30, 1'b1, 6'd30}, {6'd45, 1'b0, 6'd0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(string req, int arch, int hit, int phys);
    lk_arch = 6'(arch);
    #1;
    check({req, " hit"}, int'(lk_hit), hit);
    check({req, " phys"}, int'(lk_phys), phys);
  endtask

  task automatic rename(int arch, int phys);
    ren_en = 1; ren_arch = 6'(arch); ren_phys = 6'(phys);
  endtask

  task automatic idle();
    ren_en = 0; ckpt_req = 0; rst_en = 0;
  endtask

  initial begin
    rst_n = 0; idle(); ren_arch = 0; ren_phys = 0; lk_arch = 0; rst_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R2: reset mapping walked from the vector table
    for (int i = 0; i < 8; i++)
      look("R1", int'(LK_VEC[i][12:7]), int'(LK_VEC[i][6]), int'(LK_VEC[i][5:0]));

    // R3: rename arch 5 -> phys 40, old claim on entry 5 dropped
    rename(5, 40); tick(); idle();
    look("R3", 5, 1, 40);

    // R4: checkpoint together with rename arch 6 -> 41
    ckpt_req = 1; rename(6, 41); #1;
    check("R4 grant", int'(ckpt_grant), 1);
    check("R4 tag0", int'(ckpt_tag), 0);
    check("R4 stall", int'(ckpt_stall), 0);
    tick(); idle();
    look("R3 arch6", 6, 1, 41);

    rename(5, 42); tick(); idle();
    look("R3 reuse", 5, 1, 42);

    for (int t = 1; t < 4; t++) begin
      ckpt_req = 1; #1;
      check("R4 tag order", int'(ckpt_tag), t);
      tick();
    end
    ckpt_req = 1; #1;
    check("R5 stall", int'(ckpt_stall), 1);
    check("R5 grant", int'(ckpt_grant), 0);
    tick(); idle();

    rename(7, 50); tick(); idle();
    look("R3 arch7", 7, 1, 50);

    // R6 / R7: restore slot 1 with rename and request pending
    rst_en = 1; rst_tag = 2'd1; rename(8, 51); ckpt_req = 1; #1;
    check("R7 grant", int'(ckpt_grant), 0);
    check("R7 stall", int'(ckpt_stall), 0);
    tick(); idle();
    look("R6 arch5", 5, 1, 42);
    look("R6 arch7", 7, 1, 7);
    look("R7 arch8", 8, 1, 8);
    ckpt_req = 1; #1;
    check("R6 next tag", int'(ckpt_tag), 1);
    check("R6 grant", int'(ckpt_grant), 1);
    tick(); idle();

    // R4 / R6: slot 0 excludes its same-cycle rename
    rst_en = 1; rst_tag = 2'd0; tick(); idle();
    look("R4 snapshot", 6, 1, 6);
    look("R6 arch5", 5, 1, 40);

    // R8: stale tag ignored, rename proceeds
    rst_en = 1; rst_tag = 2'd2; rename(9, 60); tick(); idle();
    look("R8 rename", 9, 1, 60);
    look("R8 table", 5, 1, 40);
    ckpt_req = 1; #1;
    check("R8 count", int'(ckpt_tag), 0);
    tick(); idle();

    look("R2 miss", 40, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule